// File: doc/BRIEF.md
# Clocked Phase-Delayed Read Strobe Generator

This block generates the timing for a slow, sequential memory read from a fast system clock. It does not use gate or routing delays for this timing. A free-running phase counter divides the fast clock by four. This gives four fast-cycle phase slots in every access period. Phase slot 0 presents a new read address together with a one-cycle address pulse. A one-cycle read strobe then follows in a later slot of the same period. The strobe is therefore offset from the address by a whole number of fast-clock cycles, from one to three, chosen by the caller. Because the offset is counted in cycles, the address is always settled before the read occurs.

Each period is either active or idle. A small state machine decides this once per period, in the last slot before the counter wraps. In that slot it also latches the requested phase. All outputs come straight from flip-flops. The divided clock is produced as registered data, never by gating a clock.

State machine (`period_state_t`):
- `ST_HOLD` is the idle period state.
- `ST_RUN` is the active period state.

Transitions happen only in slot 3:
- *resume* (`ST_HOLD`→`ST_RUN`) when `enable` is high.
- *pause* (`ST_RUN`→`ST_HOLD`) when `enable` is low.
- *stay* in the current state otherwise.
- *reset* forces `ST_HOLD` from any state.

Top module: `rdstb_gen`

## Requirements
- R1: While `rst` is high, the outputs after each clock edge are as follows: `addr_stb` and `rd_stb` are 0, `rd_addr` is 0, and `acc_clk` is 1.
- R2: `acc_clk` has a period of four fast cycles. It is high in slots 0 and 1 and low in slots 2 and 3. It rises in the cycle where `addr_stb` would be asserted.
- R3: In every active period, `addr_stb` is high for exactly one cycle, in slot 0. It is low in all other slots and throughout idle periods.
- R4: `rd_addr` rises by one in the same cycle that `addr_stb` is high, and is held at all other times. It wraps from all-ones to 0. The first access after reset therefore uses address 1.
- R5: In an active period whose latched phase is k (1 to 3), `rd_stb` is high for exactly one cycle, in slot k. That is k cycles after `addr_stb`.
- R6: A `phase_sel` value of 0 is treated as 1.
- R7: `phase_sel` and `enable` are sampled only in slot 3, and they govern the following period. Changing them in slots 0 to 2 has no effect on the outputs.
- R8: If `enable` is low when it is sampled, the next period is idle. In an idle period there is no `addr_stb`, no `rd_stb`, and `rd_addr` keeps its value.
- R9: After `rst` is released, the counter runs through slots 1, 2 and 3 with no strobe. The earliest `addr_stb` falls in the fourth cycle after release.
- R10: Between two consecutive `addr_stb` pulses, where the earlier one began an active period, exactly one `rd_stb` occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock (four times the access rate) |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Request for active access periods, sampled in slot 3 |
| phase_sel | input | PHASE_W | Read-strobe slot (1 to 3), sampled in slot 3 |
| acc_clk | output | 1 | Divided access clock, registered data |
| addr_stb | output | 1 | One-cycle pulse marking a new read address |
| rd_stb | output | 1 | One-cycle read strobe, lagging the address pulse |
| rd_addr | output | AW | Sequential read address |

## Verification
Each output reflects the counter slot and the period state in the same cycle as the internal counter, with one register stage. A `phase_sel` or `enable` value present in slot 3 therefore first shows up at slot 0 of the next period, one edge later. Its read strobe then appears k further cycles on. The bench keeps its own slot counter, active flag and latched phase, which it advances at each rising edge from the requirements. It compares all outputs at the following falling edge. The comparison therefore covers exactly the cycle in which each result is due. The bench also counts read strobes between address pulses, independently of its slot model.

// File: rtl/rdstb_pkg.sv
package rdstb_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } period_state_t;

endpackage

// File: rtl/rdstb_phase_ctr.sv
module rdstb_phase_ctr #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PHASE_W-1:0] cnt_q,
    output logic [PHASE_W-1:0] cnt_d,
    output logic               wrap
);
    localparam logic [PHASE_W-1:0] LAST_SLOT = '1;

    always_comb begin
        if (rst) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PHASE_W'(1);
        end
    end

    assign wrap = (cnt_q == LAST_SLOT);

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rdstb_period_fsm.sv
module rdstb_period_fsm
    import rdstb_pkg::*;
#(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap,
    input  logic               enable,
    input  logic [PHASE_W-1:0] phase_sel,
    output period_state_t      state_d,
    output logic [PHASE_W-1:0] sel_d
);
    localparam logic [PHASE_W-1:0] MIN_LAG = PHASE_W'(1);

    period_state_t      state_q;
    logic [PHASE_W-1:0] sel_q;
    logic [PHASE_W-1:0] sel_legal;

    assign sel_legal = (phase_sel == '0) ? MIN_LAG : phase_sel;

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        if (rst) begin
            state_d = ST_HOLD;
            sel_d   = MIN_LAG;
        end else if (wrap) begin
            sel_d = sel_legal;
            unique case (state_q)
                ST_HOLD: state_d = enable ? ST_RUN : ST_HOLD;
                ST_RUN:  state_d = enable ? ST_RUN : ST_HOLD;
                default: state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        sel_q   <= sel_d;
    end
endmodule

// File: rtl/rdstb_out_reg.sv
module rdstb_out_reg
    import rdstb_pkg::*;
#(
    parameter int PHASE_W = 2,
    parameter int AW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] cnt_d,
    input  period_state_t      state_d,
    input  logic [PHASE_W-1:0] sel_d,
    output logic               acc_clk,
    output logic               addr_stb,
    output logic               rd_stb,
    output logic [AW-1:0]      rd_addr
);
    logic active_d;
    logic addr_stb_d;
    logic rd_stb_d;

    always_comb begin
        active_d   = (state_d == ST_RUN);
        addr_stb_d = active_d && (cnt_d == '0);
        rd_stb_d   = active_d && (cnt_d == sel_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_clk  <= 1'b1;
            addr_stb <= 1'b0;
            rd_stb   <= 1'b0;
            rd_addr  <= '0;
        end else begin
            acc_clk  <= ~cnt_d[PHASE_W-1];
            addr_stb <= addr_stb_d;
            rd_stb   <= rd_stb_d;
            if (addr_stb_d) begin
                rd_addr <= rd_addr + AW'(1);
            end
        end
    end
endmodule

// File: rtl/rdstb_gen.sv
module rdstb_gen
    import rdstb_pkg::*;
#(
    parameter int PHASE_W = 2,
    parameter int AW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [PHASE_W-1:0] phase_sel,
    output logic               acc_clk,
    output logic               addr_stb,
    output logic               rd_stb,
    output logic [AW-1:0]      rd_addr
);
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] cnt_d;
    logic               wrap;
    period_state_t      state_d;
    logic [PHASE_W-1:0] sel_d;

    rdstb_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d),
        .wrap  (wrap)
    );

    rdstb_period_fsm #(.PHASE_W(PHASE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .enable    (enable),
        .phase_sel (phase_sel),
        .state_d   (state_d),
        .sel_d     (sel_d)
    );

    rdstb_out_reg #(.PHASE_W(PHASE_W), .AW(AW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .cnt_d    (cnt_d),
        .state_d  (state_d),
        .sel_d    (sel_d),
        .acc_clk  (acc_clk),
        .addr_stb (addr_stb),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr)
    );
endmodule

// File: rtl/rdstb_gen_chk.sv
module rdstb_gen_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_clk,
    input logic          addr_stb,
    input logic          rd_stb,
    input logic [AW-1:0] rd_addr
);
    logic rd_seen;
    logic had_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen    <= 1'b0;
            had_active <= 1'b0;
        end else begin
            if (addr_stb) begin
                rd_seen    <= 1'b0;
                had_active <= 1'b1;
            end else if (rd_stb) begin
                rd_seen <= 1'b1;
            end
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!addr_stb && !rd_stb && rd_addr == '0 && acc_clk));

    // R2
    a_r2_clk_rises_on_addr: assert property (@(posedge clk) disable iff (rst)
        addr_stb |-> (acc_clk && !$past(acc_clk)));

    // R3
    a_r3_addr_single: assert property (@(posedge clk) disable iff (rst)
        addr_stb |=> !addr_stb);

    // R4
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        addr_stb |-> (rd_addr == $past(rd_addr) + AW'(1)));

    // R4
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !addr_stb |-> $stable(rd_addr));

    // R5
    a_r5_lag_window: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> (!addr_stb &&
                   ($past(addr_stb) || $past(addr_stb, 2) || $past(addr_stb, 3))));

    // R10
    a_r10_no_double_read: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> !rd_seen);

    // R10
    a_r10_read_before_next: assert property (@(posedge clk) disable iff (rst)
        (addr_stb && had_active) |-> rd_seen);
endmodule

bind rdstb_gen rdstb_gen_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_clk  (acc_clk),
    .addr_stb (addr_stb),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr)
);

// File: tb/tb_rdstb_gen.sv
module tb_rdstb_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [PW-1:0] phase_sel = 2'd1;
    logic          acc_clk, addr_stb, rd_stb;
    logic [AW-1:0] rd_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state
    logic [PW-1:0] m_cnt = '0;
    logic          m_run = 1'b0;
    logic [PW-1:0] m_sel = 2'd1;
    logic [AW-1:0] m_addr = '0;
    int            rd_since = 0;
    bit            armed = 1'b0;
    int            wraps_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdstb_gen #(.PHASE_W(PW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .enable(enable), .phase_sel(phase_sel),
        .acc_clk(acc_clk), .addr_stb(addr_stb), .rd_stb(rd_stb), .rd_addr(rd_addr)
    );

    function automatic logic [PW-1:0] legal_sel(input logic [PW-1:0] s);
        return (s == '0) ? 2'd1 : s;
    endfunction

    always @(posedge clk) begin
        logic [PW-1:0] nc;
        logic          nrun;
        logic [PW-1:0] nsel;
        if (rst) begin
            m_cnt <= '0; m_run <= 1'b0; m_sel <= 2'd1; m_addr <= '0;
        end else begin
            nc = m_cnt + 2'd1;
            nrun = m_run;
            nsel = m_sel;
            if (m_cnt == 2'd3) begin
                nrun = enable;
                nsel = legal_sel(phase_sel);
            end
            if (nrun && nc == '0) begin
                if (m_addr == '1) wraps_seen <= wraps_seen + 1;
                m_addr <= m_addr + 1'b1;
            end
            m_cnt <= nc; m_run <= nrun; m_sel <= nsel;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        logic e_addr, e_rd, e_clk;
        @(negedge clk);
        if (rst) begin
            chk(!addr_stb && !rd_stb && rd_addr == '0 && acc_clk == 1'b1, "R1 reset outputs",
                {addr_stb, rd_stb, acc_clk}, 3'b001);
            rd_since = 0; armed = 1'b0;
            return;
        end
        e_addr = m_run && (m_cnt == '0);
        e_rd   = m_run && (m_cnt == m_sel);
        e_clk  = (m_cnt < 2'd2);
        chk(acc_clk == e_clk, "R2 acc_clk", acc_clk, e_clk);
        chk(addr_stb == e_addr, {"R3 addr_stb ", tag}, addr_stb, e_addr);
        chk(rd_addr == m_addr, {"R4 rd_addr ", tag}, rd_addr, m_addr);
        chk(rd_stb == e_rd, {"R5 rd_stb ", tag}, rd_stb, e_rd);
        if (addr_stb) begin
            if (armed) chk(rd_since == 1, "R10 reads per period", rd_since, 1);
            armed = 1'b1;
            rd_since = 0;
        end else if (rd_stb) begin
            rd_since++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) step("R1");
        rst = 1'b0;
        // R9: slots 1..3 after release are strobe-free
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!addr_stb && !rd_stb, "R9 quiet after release", {addr_stb, rd_stb}, 0);
        end
        step("R9");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // R5: each legal phase held steadily
        enable = 1'b1;
        for (int p = 1; p < 4; p++) begin
            phase_sel = PW'(p);
            repeat (24) step("R5");
        end
        // R6: zero select behaves as one
        phase_sel = 2'd0;
        repeat (24) step("R6");
        // R8: idle periods keep the address
        enable = 1'b0;
        repeat (20) step("R8");
        enable = 1'b1;
        phase_sel = 2'd3;
        repeat (8) step("R8");
        // R7: inputs toggled every cycle
        for (int i = 0; i < 3000; i++) begin
            phase_sel = PW'($urandom % 4);
            enable = (($urandom % 6) != 0);
            step("R7");
        end
        // R4: long run through the address wrap
        enable = 1'b1;
        phase_sel = 2'd2;
        wraps_seen = 0;
        repeat (1100) step("R4");
        chk(wraps_seen >= 1, "R4 wrap reached", wraps_seen, 1);
        // R1/R9: reset in mid-run, then resume
        do_reset();
        repeat (40) step("R9");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule